// File: doc/BRIEF.md
# Microphone Capture Sample Packer and Receive FIFO

This block sits behind a multi-channel pulse-density microphone decimator. Each decimated sample arrives as a signed 21-bit value tagged with its channel slot. The block gates the sample by channel and by a global switch. It repacks the sample into a 32-bit word in one of four layouts and queues the word in a receive FIFO. A DMA engine drains the FIFO through a read port in bursts of eight words.

A small 32-bit register file sets up the capture path. It holds:
- the global and per-channel enables and the active channel count;
- the word layout (resolution and justification);
- the DMA request enable, a self-clearing flush and the write-one-to-clear status flags;
- the FIFO read port.

The sample-rate code, the oversample select and the per-channel high-pass enables are only stored here. They are driven out to the decimator. A 1-bit count setting is only stored and read back.

Top module: `pdm_capture_fifo`

## Requirements
- R1: After reset every writable field reads 0, the status register reads 0, `dma_req` is 0, and offset 0x50 returns the `VERSION` parameter (default 0x0002_0100).
- R2: A sample with `smp_valid` high is queued only when all three hold: the global enable (bit 8 at 0x00) is 1, the slot's bit in the channel mask (bits 7:0 at 0x00) is 1, and the slot is not above the channel-count field. Otherwise the sample is dropped.
- R3: The channel-count field (bits 2:0 at 0x24) holds N, and slots 0..N are active. With N=2, only slots 0, 1 and 2 are queued.
- R4: Layout bits sit in 0x1C: bit 9 selects low justification and bit 8 selects 24-bit resolution. With bit 9 = 1 and bit 8 = 0, the word is the top 16 bits of the sample, sign-extended to 32 bits (the sample arithmetically shifted right by 5).
- R5: With bit 9 = 1 and bit 8 = 1, the word is the sample followed by three zero bits, sign-extended to 32 bits (the sample times 8).
- R6: With bit 9 = 0 the word is high-justified.
  - Bit 8 = 1: the sample sits in bits 31:11 with zeros below it.
  - Bit 8 = 0: the top 16 sample bits sit in bits 31:16 with zeros below them.
- R7: Reading 0x10 pops words in the order they were queued. A read of an empty FIFO returns 0 and leaves the FIFO unchanged. The FIFO holds `DEPTH` words (default 64).
- R8: A sample that passes the gating while the FIFO is full is dropped and sets the overrun flag (bit 1 at 0x18). Writing 1 to that bit clears it.
- R9: The data flag (bit 0 at 0x18) is set on every cycle the FIFO holds data. Writing 1 clears it only once the FIFO is empty.
- R10: Writing 1 to bit 31 of 0x1C empties the FIFO within two cycles. That bit always reads 0, and bits 9:8 keep the value written alongside it.
- R11: `dma_req` is high exactly while the request enable (bit 2 at 0x14) is 1 and the FIFO holds at least `BURST` (default 8) words.
- R12: The following fields drive their outputs directly and read back:
  - rate code (bits 2:0 at 0x04) on `rate_code`;
  - oversample select (bit 0 at 0x08) on `osr_high`;
  - high-pass mask (bits 7:0 at 0x38) on `hpf_en`.
  The count bit (bit 0 at 0x2C) reads back. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at 0x10) |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the offset |
| smp_valid | input | 1 | Decimated sample valid |
| smp_slot | input | 3 | Channel slot of the sample |
| smp_data | input | 21 | Signed sample |
| dma_req | output | 1 | DMA burst request |
| rate_code | output | 3 | Stored rate code |
| osr_high | output | 1 | Stored oversample select |
| hpf_en | output | 8 | Stored high-pass enables |

## Verification
The checker assumes the following about the inputs:
- register writes and reads are never strobed in the same cycle;
- a FIFO pop and a gated sample do not coincide with a full FIFO, so the fill level moves by at most one per cycle except on a flush.

The stimulus keeps to this by issuing register accesses and samples in separate cycles from tasks driven on the falling edge. Each format setting is swept over extreme and spread sample values. Each channel count, mask and overflow case is then drained through the read port.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
   typedef enum logic [7:0] {
      OFF_ENABLE  = 8'h00,
      OFF_RATE    = 8'h04,
      OFF_CTRL    = 8'h08,
      OFF_DATA    = 8'h10,
      OFF_DMACTL  = 8'h14,
      OFF_STATUS  = 8'h18,
      OFF_FIFOCTL = 8'h1C,
      OFF_CHCOUNT = 8'h24,
      OFF_COUNT   = 8'h2C,
      OFF_HPF     = 8'h38,
      OFF_VERSION = 8'h50
   } reg_off_e;

   // bit positions decoded by software and the DMA path
   localparam int unsigned B_GLOBAL  = 8;
   localparam int unsigned B_RES24   = 8;
   localparam int unsigned B_LOWJUST = 9;
   localparam int unsigned B_FLUSH   = 31;
   localparam int unsigned B_DRQ     = 2;
   localparam int unsigned B_PEND    = 0;
   localparam int unsigned B_OVR     = 1;
endpackage

// File: rtl/pdm_cap_pack.sv
module pdm_cap_pack #(
   parameter int unsigned SAMPLE_W = 21,
   parameter int unsigned SHORT_W  = 16,
   parameter int unsigned LONG_W   = 24,
   parameter int unsigned WORD_W   = 32
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                res24,
   input  logic                low_just,
   output logic [WORD_W-1:0]   word
);
   localparam int unsigned LPAD = LONG_W - SAMPLE_W;

   generate
      if (SHORT_W >= SAMPLE_W || LONG_W <= SAMPLE_W || WORD_W <= LONG_W) begin : g_bad_widths
         $error("pdm_cap_pack: need SHORT_W < SAMPLE_W < LONG_W < WORD_W");
      end
   endgenerate

   logic [SHORT_W-1:0] short_s;
   logic [LONG_W-1:0]  long_s;
   logic [WORD_W-1:0]  low_word;
   logic [WORD_W-1:0]  high_word;

   assign short_s = sample[SAMPLE_W-1 -: SHORT_W];
   assign long_s  = {sample, {LPAD{1'b0}}};

   always_comb begin
      if (res24) begin
         low_word  = {{(WORD_W-LONG_W){long_s[LONG_W-1]}}, long_s};
         high_word = {sample, {(WORD_W-SAMPLE_W){1'b0}}};
      end else begin
         low_word  = {{(WORD_W-SHORT_W){short_s[SHORT_W-1]}}, short_s};
         high_word = {short_s, {(WORD_W-SHORT_W){1'b0}}};
      end
      word = low_just ? low_word : high_word;
   end
endmodule

// File: rtl/pdm_cap_fifo.sv
module pdm_cap_fifo #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [WORD_W-1:0] din,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic [CW-1:0]     fill,
   output logic              full,
   output logic              empty
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("pdm_cap_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic              do_push, do_pop;

   assign full    = (fill == CW'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else if (flush) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/pdm_cap_regs.sv
module pdm_cap_regs
   import pdm_cap_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned WORD_W  = 32,
   parameter logic [31:0] VERSION = 32'h0002_0100,
   localparam int unsigned SW     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [WORD_W-1:0] fifo_head,
   input  logic              fifo_empty,
   input  logic              ovr_evt,
   output logic [NUM_CH-1:0] ch_mask,
   output logic              glb_en,
   output logic [SW-1:0]     ch_last,
   output logic              res24,
   output logic              low_just,
   output logic              drq_en,
   output logic              fifo_pop,
   output logic              fifo_flush,
   output logic              ovr_flag,
   output logic [2:0]        rate_code,
   output logic              osr_high,
   output logic [NUM_CH-1:0] hpf_en
);
   generate
      if (NUM_CH < 2 || NUM_CH > 8 || (1 << SW) != NUM_CH) begin : g_bad_ch
         $error("pdm_cap_regs: NUM_CH must be 2, 4 or 8");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("pdm_cap_regs: read port is 32 bits wide");
      end
   endgenerate

   logic pend_q, ovr_q, flush_q, count_q;
   logic wr_stat;

   assign wr_stat    = wr && (addr == OFF_STATUS);
   assign fifo_flush = flush_q;
   assign ovr_flag   = ovr_q;
   assign fifo_pop   = rd && (addr == OFF_DATA) && !fifo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_mask   <= '0;
         glb_en    <= 1'b0;
         ch_last   <= '0;
         res24     <= 1'b0;
         low_just  <= 1'b0;
         drq_en    <= 1'b0;
         rate_code <= '0;
         osr_high  <= 1'b0;
         hpf_en    <= '0;
         count_q   <= 1'b0;
         flush_q   <= 1'b0;
         pend_q    <= 1'b0;
         ovr_q     <= 1'b0;
      end else begin
         flush_q <= 1'b0;
         if (wr) begin
            case (addr)
               OFF_ENABLE: begin
                  ch_mask <= wdata[NUM_CH-1:0];
                  glb_en  <= wdata[B_GLOBAL];
               end
               OFF_RATE:    rate_code <= wdata[2:0];
               OFF_CTRL:    osr_high  <= wdata[0];
               OFF_DMACTL:  drq_en    <= wdata[B_DRQ];
               OFF_FIFOCTL: begin
                  res24    <= wdata[B_RES24];
                  low_just <= wdata[B_LOWJUST];
                  flush_q  <= wdata[B_FLUSH];
               end
               OFF_CHCOUNT: ch_last <= wdata[SW-1:0];
               OFF_COUNT:   count_q <= wdata[0];
               OFF_HPF:     hpf_en  <= wdata[NUM_CH-1:0];
               default: ;
            endcase
         end
         pend_q <= (pend_q && !(wr_stat && wdata[B_PEND])) || !fifo_empty;
         ovr_q  <= (ovr_q && !(wr_stat && wdata[B_OVR])) || ovr_evt;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            OFF_ENABLE:  begin
               rdata[NUM_CH-1:0] = ch_mask;
               rdata[B_GLOBAL]   = glb_en;
            end
            OFF_RATE:    rdata[2:0] = rate_code;
            OFF_CTRL:    rdata[0]   = osr_high;
            OFF_DATA:    rdata      = fifo_empty ? '0 : fifo_head;
            OFF_DMACTL:  rdata[B_DRQ] = drq_en;
            OFF_STATUS:  begin
               rdata[B_PEND] = pend_q;
               rdata[B_OVR]  = ovr_q;
            end
            OFF_FIFOCTL: begin
               rdata[B_RES24]   = res24;
               rdata[B_LOWJUST] = low_just;
            end
            OFF_CHCOUNT: rdata[SW-1:0] = ch_last;
            OFF_COUNT:   rdata[0] = count_q;
            OFF_HPF:     rdata[NUM_CH-1:0] = hpf_en;
            OFF_VERSION: rdata = VERSION;
            default:     rdata = '0;
         endcase
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[30:10], wdata[7:3]};
endmodule

// File: rtl/pdm_capture_fifo.sv
module pdm_capture_fifo #(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned SAMPLE_W = 21,
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned BURST    = 8,
   parameter logic [31:0] VERSION  = 32'h0002_0100,
   localparam int unsigned SW      = $clog2(NUM_CH),
   localparam int unsigned CW      = $clog2(DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [7:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic                smp_valid,
   input  logic [SW-1:0]       smp_slot,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic                dma_req,
   output logic [2:0]          rate_code,
   output logic                osr_high,
   output logic [NUM_CH-1:0]   hpf_en
);
   localparam int unsigned WORD_W = 32;

   generate
      if (BURST < 1 || BURST > DEPTH) begin : g_bad_burst
         $error("pdm_capture_fifo: BURST must lie in 1..DEPTH");
      end
   endgenerate

   logic [NUM_CH-1:0] ch_mask;
   logic              glb_en, res24, low_just, drq_en;
   logic [SW-1:0]     ch_last;
   logic              fifo_pop, fifo_flush, ovr_flag;
   logic [WORD_W-1:0] packed_word, fifo_head;
   logic [CW-1:0]     fifo_fill;
   logic              fifo_full, fifo_empty;
   logic              smp_take, ovr_evt;

   assign smp_take = smp_valid && glb_en && ch_mask[smp_slot] && (smp_slot <= ch_last);
   assign ovr_evt  = smp_take && fifo_full;
   assign dma_req  = drq_en && (fifo_fill >= CW'(BURST));

   pdm_cap_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .VERSION(VERSION)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .fifo_head(fifo_head),
      .fifo_empty(fifo_empty), .ovr_evt(ovr_evt), .ch_mask(ch_mask),
      .glb_en(glb_en), .ch_last(ch_last), .res24(res24), .low_just(low_just),
      .drq_en(drq_en), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
      .ovr_flag(ovr_flag), .rate_code(rate_code), .osr_high(osr_high),
      .hpf_en(hpf_en)
   );

   pdm_cap_pack #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_pack (
      .sample(smp_data), .res24(res24), .low_just(low_just), .word(packed_word)
   );

   pdm_cap_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(smp_take),
      .din(packed_word), .pop(fifo_pop), .head(fifo_head), .fill(fifo_fill),
      .full(fifo_full), .empty(fifo_empty)
   );
endmodule

// File: rtl/pdm_capture_fifo_chk.sv
module pdm_capture_fifo_chk #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned BURST = 8,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dma_req,
   input logic [CW-1:0] fill,
   input logic          push,
   input logic          pop,
   input logic          flush,
   input logic          ovr
);
   // R7: occupancy never exceeds the storage
   a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   // R7: occupancy moves by at most one word per cycle outside a flush
   a_r7_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (fill == $past(fill) || fill == $past(fill) + 1'b1 || fill + 1'b1 == $past(fill)));

   // R10: a flush leaves the FIFO empty
   a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> fill == '0);

   // R8: a sample offered to a full FIFO is dropped and flagged
   a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CW'(DEPTH) && push && !pop && !flush) |=> (fill == CW'(DEPTH) && ovr));

   // R11: popping the last word of a burst drops the request
   a_r11_req_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && pop && !push && !flush && fill == CW'(BURST)) |=> !dma_req);
endmodule

bind pdm_capture_fifo pdm_capture_fifo_chk #(.DEPTH(DEPTH), .BURST(BURST)) u_chk (
   .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .fill(fifo_fill),
   .push(smp_take), .pop(fifo_pop), .flush(fifo_flush), .ovr(ovr_flag)
);

// File: tb/test_pdm_capture_fifo.sv
module test_pdm_capture_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_slot = '0;
   logic [20:0] smp_data = '0;
   logic        dma_req, osr_high;
   logic [2:0]  rate_code;
   logic [7:0]  hpf_en;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pdm_capture_fifo i_pdm_capture_fifo (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .smp_valid(smp_valid), .smp_slot(smp_slot), .smp_data(smp_data),
      .dma_req(dma_req), .rate_code(rate_code), .osr_high(osr_high),
      .hpf_en(hpf_en)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic push(input int slot, input logic [20:0] v);
      @(negedge clk);
      smp_valid = 1'b1; smp_slot = 3'(slot); smp_data = v;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   function automatic logic [31:0] fmt(input logic [20:0] v, input bit lowj, input bit r24);
      int si;
      si = int'({{11{v[20]}}, v});
      if (lowj) return r24 ? 32'(si * 8) : 32'(si >>> 5);
      return r24 ? 32'(si <<< 11) : 32'((si >>> 5) <<< 16);
   endfunction

   task automatic drain_expect_empty(input string tag);
      logic [31:0] d;
      rd(8'h10, d);
      check(tag, d, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [20:0] vals [12];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, d); check("R1 enable", d, 0);
      rd(8'h1C, d); check("R1 fifoctl", d, 0);
      rd(8'h24, d); check("R1 chcount", d, 0);
      rd(8'h18, d); check("R1 status", d, 0);
      check("R1 dma_req", 32'(dma_req), 0);
      rd(8'h50, d); check("R1 version", d, 32'h0002_0100);

      // R2 global enable off: nothing queued
      wr(8'h24, 7); wr(8'h00, 32'h0FF); wr(8'h1C, 32'h300);
      push(0, 21'h123);
      drain_expect_empty("R2 global off");
      // R2 mask gating: only slots 0 and 2
      wr(8'h00, 32'h105);
      for (int s = 0; s < 8; s++) push(s, 21'(s + 1));
      rd(8'h10, d); check("R2 slot0", d, fmt(21'd1, 1, 1));
      rd(8'h10, d); check("R2 slot2", d, fmt(21'd3, 1, 1));
      drain_expect_empty("R2 masked slots");

      // R3 channel count N=2
      wr(8'h00, 32'h1FF); wr(8'h24, 2);
      for (int s = 0; s < 8; s++) push(s, 21'(s + 1));
      for (int s = 0; s < 3; s++) begin
         rd(8'h10, d); check("R3 active slot", d, fmt(21'(s + 1), 1, 1));
      end
      drain_expect_empty("R3 slots above N");
      wr(8'h24, 7);

      // R4 R5 R6 layout sweep
      for (int k = 0; k < 12; k++) vals[k] = 21'(k * 98765 + 4321);
      vals[0] = 21'h000000; vals[1] = 21'h1FFFFF; vals[2] = 21'h0FFFFF; vals[3] = 21'h100000;
      for (int m = 0; m < 4; m++) begin
         bit lowj, r24;
         lowj = m[1]; r24 = m[0];
         wr(8'h1C, (32'(lowj) << 9) | (32'(r24) << 8));
         for (int k = 0; k < 12; k++) push(k % 8, vals[k]);
         for (int k = 0; k < 12; k++) begin
            rd(8'h10, d);
            if (lowj && !r24) check("R4 low 16", d, fmt(vals[k], lowj, r24));
            else if (lowj)    check("R5 low 24", d, fmt(vals[k], lowj, r24));
            else              check("R6 high", d, fmt(vals[k], lowj, r24));
         end
      end

      // R11 DMA request threshold
      wr(8'h1C, 32'h300); wr(8'h14, 32'h4);
      for (int k = 0; k < 7; k++) push(k, 21'(k + 1));
      check("R11 below burst", 32'(dma_req), 0);
      push(7, 21'd8);
      check("R11 at burst", 32'(dma_req), 1);
      wr(8'h14, 0);
      check("R11 disabled", 32'(dma_req), 0);
      wr(8'h14, 32'h4);
      rd(8'h10, d);
      check("R11 after pop", 32'(dma_req), 0);
      wr(8'h14, 0);
      for (int k = 1; k < 8; k++) rd(8'h10, d);

      // R9 data flag clears once empty
      wr(8'h18, 1);
      rd(8'h18, d); check("R9 pend cleared", d, 0);
      push(0, 21'd5);
      wr(8'h18, 1);
      rd(8'h18, d); check("R9 pend while data", d, 1);
      rd(8'h10, d); check("R7 pop", d, 32'd40);

      // R8 overrun: fill 64, one extra dropped
      for (int k = 0; k < 65; k++) push(k % 8, 21'(k + 1));
      rd(8'h18, d); check("R8 overrun flag", d & 2, 2);
      for (int k = 0; k < 64; k++) begin
         rd(8'h10, d); check("R7 order", d, 32'((k + 1) * 8));
      end
      drain_expect_empty("R8 extra dropped");
      wr(8'h18, 3);
      rd(8'h18, d); check("R8 cleared", d, 0);

      // R10 flush
      for (int k = 0; k < 5; k++) push(k, 21'(k + 9));
      wr(8'h1C, 32'h8000_0300);
      @(negedge clk);
      rd(8'h1C, d); check("R10 readback", d, 32'h300);
      drain_expect_empty("R10 flushed");

      // R12 exported fields
      wr(8'h04, 5); wr(8'h08, 1); wr(8'h38, 32'hA5); wr(8'h2C, 1);
      check("R12 rate out", 32'(rate_code), 5);
      check("R12 osr out", 32'(osr_high), 1);
      check("R12 hpf out", 32'(hpf_en), 32'hA5);
      rd(8'h04, d); check("R12 rate rb", d, 5);
      rd(8'h2C, d); check("R12 count rb", d, 1);
      rd(8'h3C, d); check("R12 unmapped", d, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule